// File: doc/BRIEF.md
# Unsigned Wallace-Tree Multiplier with Carry-Select Final Adder

This block multiplies two unsigned operands and returns the full double-width product. The arithmetic works in three steps. First, an AND array forms one partial-product row per bit of the second operand. Next, layers of 3:2 compressors in a Wallace tree shrink those rows to two. Finally, a carry-select adder built from 4-bit blocks adds the last two rows.

Every one-bit adder cell is an 8:1 multiplexer. Its select lines are the cell's three input bits, and its data inputs are constant sum and carry patterns. No XOR or AND-OR gates are used in the cell. The multiplier is purely combinational from operands to result. A single output register, enabled by a small control unit once reset is released, gives the product one clock of latency. Operand width is a parameter, and an 8-bit build behaves like a scaled copy of the default 32-bit build.

Top module: `wallace_mul`

## Requirements
- R1: For WIDTH-bit unsigned operands, `product` equals the exact 2*WIDTH-bit value opA*opB, with no truncation or rounding. This holds for zero, one, all-ones and arbitrary operand pairs.
- R2: Each one-bit adder cell is an 8:1 multiplexer indexed by {a,b,cin}, with a as the most significant select bit. For select values 0 to 7 the sum output is 0,1,1,0,1,0,0,1 and the carry output is 0,0,0,1,0,1,1,1. Together, {carry,sum} equals a+b+cin for all 8 combinations.
- R3: Partial-product bit (i,j) is opA[i] AND opB[j] and carries weight i+j. So the operands 2^i and 2^j give the product 2^(i+j) for every bit position.
- R4: The compressor layers reduce the rows until exactly two remain. The sum of those two rows, modulo 2^(2*WIDTH), equals the true product.
- R5: The final adder is a chain of 4-bit carry-select blocks. The chain's carry-in is 0, and the carry out of the top block is dropped. Each block computes its sum with both carry-in 0 and carry-in 1, and the real incoming carry picks the sum and the block carry-out. Carries must travel correctly across every block boundary, for example in (2^W-1)*(2^W-1) and (2^W-1)*1.
- R6: Operands present at a rising clock edge, after the first capture, appear on `product` just after that edge. Until that edge, `product` keeps its previous value.
- R7: While `rstN` is low, `product` is 0. Capturing begins at the first rising edge after `rstN` goes high and continues from then on.
- R8: A build with WIDTH=8 gives the exact 16-bit product for all 65,536 operand pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | WIDTH | Unsigned multiplicand |
| opB | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Registered unsigned product |

## Verification
Several properties are checked in every cycle by assertions placed inside the logic:
- every multiplexer adder cell, every row compressor and every carry-select block matches its arithmetic sum;
- the two rows left by the tree always add up to the true product;
- the register loads the product of the previous operands and holds its value when not enabled;
- the capture strobe stays on once it is set.

Some behaviours can only be shown by the bench's scenarios:
- the product reads zero during reset;
- the one-cycle latency holds, seen at the port;
- carries run across the full block chain;
- single-bit weights are correct at every position;
- random pairs give exact products;
- the 8-bit build is exact over every operand pair.

// File: rtl/wtm_pkg.sv
`timescale 1ns/1ps
package wtm_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic capture;   // load the output register this cycle
  } dp_strobe_t;

  // Rows left after one layer of 3:2 compression on n rows.
  function automatic int rowsAfter(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  // Rows entering layer l when the tree starts with n rows.
  function automatic int rowsAtLayer(input int n, input int l);
    int r;
    r = n;
    for (int k = 0; k < l; k++) r = rowsAfter(r);
    return r;
  endfunction

  // Layers needed to bring n rows down to two.
  function automatic int layerCount(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = rowsAfter(r);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/mux_full_adder.sv
`timescale 1ns/1ps
// One-bit adder cell realised as an 8:1 lookup multiplexer.
module mux_full_adder (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic carry
);
  // Data inputs of the two multiplexers, bit k selected by index k.
  localparam logic [7:0] SUM_LUT   = 8'b1001_0110;
  localparam logic [7:0] CARRY_LUT = 8'b1110_1000;

  logic [2:0] sel;
  assign sel   = {a, b, cin};
  assign sum   = SUM_LUT[sel];
  assign carry = CARRY_LUT[sel];

  always_comb begin
    if (!$isunknown(sel)) begin
      assert_fa_matches_add_R2: assert ({carry, sum} == 2'(a) + 2'(b) + 2'(cin))
        else $error("mux adder cell disagrees with a+b+cin");
    end
  end
endmodule

// File: rtl/row_compressor.sv
`timescale 1ns/1ps
// 3:2 compressor across a full row: three rows in, a sum row and a
// shifted carry row out. Bits above the row width are dropped.
module row_compressor #(
  parameter int W = 64
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sumRow,
  output logic [W-1:0] carryRow
);
  logic [W-2:0] carryRaw;
  logic         unusedTopCarry;

  for (genvar k = 0; k < W; k++) begin : gen_col
    if (k == W - 1) begin : gen_top
      mux_full_adder u_fa (
        .a(x[k]), .b(y[k]), .cin(z[k]),
        .sum(sumRow[k]), .carry(unusedTopCarry)
      );
    end else begin : gen_body
      mux_full_adder u_fa (
        .a(x[k]), .b(y[k]), .cin(z[k]),
        .sum(sumRow[k]), .carry(carryRaw[k])
      );
    end
  end

  assign carryRow = {carryRaw, 1'b0};

  always_comb begin
    if (!$isunknown({x, y, z})) begin
      assert_compress_keeps_sum_R4: assert (W'(sumRow + carryRow) == W'(x + y + z))
        else $error("row compressor lost value");
    end
  end
endmodule

// File: rtl/csa_block.sv
`timescale 1ns/1ps
// Carry-select block: two ripple chains, one per assumed carry-in,
// and a final selection by the real carry.
module csa_block #(
  parameter int BLK = 4
) (
  input  logic [BLK-1:0] a,
  input  logic [BLK-1:0] b,
  input  logic           cin,
  output logic [BLK-1:0] sum,
  output logic           cout
);
  logic [BLK:0]   chain0;
  logic [BLK:0]   chain1;
  logic [BLK-1:0] sum0;
  logic [BLK-1:0] sum1;

  assign chain0[0] = 1'b0;
  assign chain1[0] = 1'b1;

  for (genvar k = 0; k < BLK; k++) begin : gen_bit
    mux_full_adder u_fa0 (
      .a(a[k]), .b(b[k]), .cin(chain0[k]),
      .sum(sum0[k]), .carry(chain0[k+1])
    );
    mux_full_adder u_fa1 (
      .a(a[k]), .b(b[k]), .cin(chain1[k]),
      .sum(sum1[k]), .carry(chain1[k+1])
    );
  end

  assign sum  = cin ? sum1 : sum0;
  assign cout = cin ? chain1[BLK] : chain0[BLK];

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      assert_block_add_R5: assert ({cout, sum} == (BLK+1)'(a) + (BLK+1)'(b) + (BLK+1)'(cin))
        else $error("carry-select block sum wrong");
    end
  end
endmodule

// File: rtl/wtm_control.sv
`timescale 1ns/1ps
// Control unit: raises the capture strobe once reset has been released.
module wtm_control (
  input  logic                  clk,
  input  logic                  rstN,
  output wtm_pkg::dp_strobe_t   strobe
);
  logic captureQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) captureQ <= 1'b0;
    else       captureQ <= 1'b1;
  end

  assign strobe.capture = captureQ;

  assert_capture_sticky_R7: assert property (
    @(posedge clk) disable iff (!rstN) captureQ |=> captureQ
  ) else $error("capture strobe dropped outside reset");
endmodule

// File: rtl/wtm_datapath.sv
`timescale 1ns/1ps
// Partial products, Wallace compression, carry-select final add and
// optional output register.
module wtm_datapath #(
  parameter int WIDTH   = 32,
  parameter int BLK     = 4,   // 2*WIDTH must be a multiple of BLK
  parameter bit OUT_REG = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wtm_pkg::dp_strobe_t   strobe,
  input  logic [WIDTH-1:0]      opA,
  input  logic [WIDTH-1:0]      opB,
  output logic [2*WIDTH-1:0]    product
);
  import wtm_pkg::*;

  localparam int PW     = 2 * WIDTH;
  localparam int LAYERS = layerCount(WIDTH);
  localparam int NBLK   = PW / BLK;

  // ---------------- partial products ----------------
  logic [PW-1:0] ppRow [WIDTH];

  for (genvar j = 0; j < WIDTH; j++) begin : gen_pp
    assign ppRow[j] = {{WIDTH{1'b0}}, opA & {WIDTH{opB[j]}}} << j;
  end

  // ---------------- Wallace layers ----------------
  for (genvar l = 0; l < LAYERS; l++) begin : gen_layer
    localparam int IN_ROWS  = rowsAtLayer(WIDTH, l);
    localparam int GROUPS   = IN_ROWS / 3;
    localparam int LEFT     = IN_ROWS % 3;
    localparam int OUT_ROWS = 2 * GROUPS + LEFT;

    logic [PW-1:0] rowsIn  [IN_ROWS];
    logic [PW-1:0] rowsOut [OUT_ROWS];

    for (genvar r = 0; r < IN_ROWS; r++) begin : gen_in
      if (l == 0) begin : gen_first
        assign rowsIn[r] = ppRow[r];
      end else begin : gen_next
        assign rowsIn[r] = gen_layer[l-1].rowsOut[r];
      end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : gen_grp
      row_compressor #(.W(PW)) u_cmp (
        .x(rowsIn[3*g]), .y(rowsIn[3*g+1]), .z(rowsIn[3*g+2]),
        .sumRow(rowsOut[2*g]), .carryRow(rowsOut[2*g+1])
      );
    end

    for (genvar r = 0; r < LEFT; r++) begin : gen_pass
      assign rowsOut[2*GROUPS+r] = rowsIn[3*GROUPS+r];
    end
  end

  logic [PW-1:0] rowA;
  logic [PW-1:0] rowB;

  if (LAYERS == 0) begin : gen_no_tree
    assign rowA = ppRow[0];
    assign rowB = ppRow[1];
  end else begin : gen_tree_out
    assign rowA = gen_layer[LAYERS-1].rowsOut[0];
    assign rowB = gen_layer[LAYERS-1].rowsOut[1];
  end

  // ---------------- carry-select final adder ----------------
  logic [PW-1:0]   sumFinal;
  logic [NBLK-1:0] blkCarry;
  logic            unusedFinalCarry;

  assign blkCarry[0] = 1'b0;

  for (genvar k = 0; k < NBLK; k++) begin : gen_blk
    if (k == NBLK - 1) begin : gen_last
      csa_block #(.BLK(BLK)) u_blk (
        .a(rowA[k*BLK +: BLK]), .b(rowB[k*BLK +: BLK]), .cin(blkCarry[k]),
        .sum(sumFinal[k*BLK +: BLK]), .cout(unusedFinalCarry)
      );
    end else begin : gen_mid
      csa_block #(.BLK(BLK)) u_blk (
        .a(rowA[k*BLK +: BLK]), .b(rowB[k*BLK +: BLK]), .cin(blkCarry[k]),
        .sum(sumFinal[k*BLK +: BLK]), .cout(blkCarry[k+1])
      );
    end
  end

  always_comb begin
    if (!$isunknown({opA, opB})) begin
      assert_two_rows_exact_R4: assert (PW'(rowA + rowB) == PW'(opA) * PW'(opB))
        else $error("tree rows do not sum to product");
    end
  end

  // ---------------- output stage ----------------
  if (OUT_REG) begin : gen_reg
    logic [PW-1:0] productQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               productQ <= '0;
      else if (strobe.capture) productQ <= sumFinal;
    end

    assign product = productQ;

    assert_load_product_R6: assert property (
      @(posedge clk) disable iff (!rstN)
        strobe.capture |=> product == $past(PW'(opA) * PW'(opB))
    ) else $error("registered product wrong");

    assert_hold_product_R6: assert property (
      @(posedge clk) disable iff (!rstN)
        !strobe.capture |=> $stable(product)
    ) else $error("product changed without capture");
  end else begin : gen_comb
    logic unusedCtl;
    assign unusedCtl = clk ^ rstN ^ strobe.capture;
    assign product   = sumFinal;
  end
endmodule

// File: rtl/wallace_mul.sv
`timescale 1ns/1ps
// Top: unsigned WIDTH x WIDTH multiplier with registered product.
module wallace_mul #(
  parameter int WIDTH   = 32,
  parameter int BLK     = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  output logic [2*WIDTH-1:0]   product
);
  wtm_pkg::dp_strobe_t strobe;

  wtm_control u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe)
  );

  wtm_datapath #(.WIDTH(WIDTH), .BLK(BLK), .OUT_REG(OUT_REG)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opA(opA), .opB(opB), .product(product)
  );
endmodule

// File: tb/wallace_mul_tb.sv
`timescale 1ns/1ps
module wallace_mul_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] opA, opB;
  logic [63:0] product;
  logic [7:0]  opA8, opB8;
  logic [15:0] product8;
  logic        faA, faB, faC, faS, faCo;

  int checks = 0;
  int fails  = 0;

  logic [63:0] qExp64 [$];
  logic [15:0] qExp16 [$];
  string       qTag   [$];

  always #2.5 clk = ~clk;   // 200 MHz

  wallace_mul u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .product(product)
  );

  wallace_mul #(.WIDTH(8)) u_dut8 (
    .clk(clk), .rstN(rstN), .opA(opA8), .opB(opB8), .product(product8)
  );

  mux_full_adder u_fa (
    .a(faA), .b(faB), .cin(faC), .sum(faS), .carry(faCo)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Driver: apply operands at the falling edge, queue expected results.
  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic [7:0] a8, input logic [7:0] b8,
                       input string tag);
    @(negedge clk);
    opA  = a;
    opB  = b;
    opA8 = a8;
    opB8 = b8;
    qExp64.push_back(64'(a) * 64'(b));
    qExp16.push_back(16'(a8) * 16'(b8));
    qTag.push_back(tag);
  endtask

  task automatic drive32(input logic [31:0] a, input logic [31:0] b, input string tag);
    drive(a, b, a[7:0], b[7:0], tag);
  endtask

  // Monitor: one result per rising edge, sampled 1 ns after it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (qExp64.size() > 0) begin
        logic [63:0] e64;
        logic [15:0] e16;
        string t;
        e64 = qExp64.pop_front();
        e16 = qExp16.pop_front();
        t   = qTag.pop_front();
        check(product === e64, {t, " 32-bit"}, product, e64);
        check(product8 === e16, {t, " 8-bit"}, 64'(product8), 64'(e16));
      end
    end
  end

  // Watchdog
  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0;
    opA = 32'hDEAD_BEEF; opB = 32'h1234_5678; opA8 = 8'hA5; opB8 = 8'h3C;
    faA = 0; faB = 0; faC = 0;

    // R2: exhaustive check of the multiplexer adder cell
    for (int v = 0; v < 8; v++) begin
      faA = v[2]; faB = v[1]; faC = v[0];
      #1;
      check({faCo, faS} == 2'(faA) + 2'(faB) + 2'(faC), "R2 mux adder cell",
            64'({faCo, faS}), 64'(2'(faA) + 2'(faB) + 2'(faC)));
    end

    // R7: product held at zero during reset despite nonzero operands
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(product === 64'd0, "R7 reset 32-bit", product, 64'd0);
    check(product8 === 16'd0, "R7 reset 8-bit", 64'(product8), 64'd0);
    opA = '0; opB = '0; opA8 = '0; opB8 = '0;
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: zero, one and identity cases
    drive32(32'd0, 32'd0, "R1 zero*zero");
    drive32(32'd0, 32'hFFFF_FFFF, "R1 zero*max");
    drive32(32'd1, 32'd1, "R1 one*one");
    drive32(32'd1, 32'h89AB_CDEF, "R1 one*x");
    drive32(32'h0001_0000, 32'h0001_0000, "R1 half*half");

    // R5: long carry runs across every carry-select block
    drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 max*max");
    drive32(32'hFFFF_FFFF, 32'd1, "R5 max*1");
    drive32(32'hFFFF_FFFF, 32'd2, "R5 max*2");
    drive32(32'h8000_0001, 32'hFFFF_FFFF, "R5 mixed carry");

    // R3: single-bit operands at every position
    for (int i = 0; i < 32; i++) begin
      drive32(32'd1 << i, 32'd1, "R3 bit*1");
      drive32(32'd1, 32'd1 << i, "R3 1*bit");
      drive32(32'd1 << i, 32'd1 << (31 - i), "R3 bit*bit");
    end

    // R6: product changes only at the edge after operands are applied
    drive32(32'd5, 32'd7, "R6 first");
    drive32(32'd9, 32'd11, "R6 second");
    #1;
    check(product === 64'd35, "R6 latency before edge", product, 64'd35);

    // R1/R4: random pairs
    for (int n = 0; n < 10000; n++) begin
      drive32($urandom, $urandom, "R1 random");
    end

    // R8: exhaustive 8-bit build
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        drive(32'(a), 32'(b), 8'(a), 8'(b), "R8 exhaustive");
      end
    end

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule